// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block creates DMA requests for logic that has no request line of its own. One of several trigger inputs is chosen through a select field. Each time an edge of the programmed kind appears on that input, the generator issues a burst of request pulses. The burst length is a programmed count plus one. Each pulse on `dma_req` stays high until the DMA side acknowledges it on `dma_ack`. The request output feeds a downstream request router like any peripheral request.

A trigger edge may arrive while an earlier burst still has requests outstanding. Such an edge is dropped and raises a sticky overrun flag, which can also drive an interrupt. Software reaches the block through a small register port. Address 0 holds the control word. Address 1 returns the overrun status in bit 0. Address 2 is a write-one-to-clear register for that flag.

The sequencer has three states. `ST_IDLE` waits for a trigger edge (transition *launch*). `ST_ASSERT` holds the request high. An acknowledge moves it either to `ST_RELEASE` (transition *next*, when requests remain) or back to `ST_IDLE` (transition *done*, after the last one). `ST_RELEASE` drops the request for one cycle and returns to `ST_ASSERT` (transition *rearm*). Clearing the enable bit forces `ST_IDLE` from any state (transition *abort*).

Top module: `trig_req_gen`

## Requirements
- R1: After reset the control word reads 0, the status reads 0, and `dma_req` and `irq` are low.
- R2: Control word fields: bit 0 enables the generator, bit 1 enables the interrupt, bits [3:2] select the edge kind, bits [8:4] hold the request count minus one, and bits [18:16] select the trigger input. Only the selected input can start a burst.
- R3: The edge kind is encoded as 00 none, 01 rising, 10 falling and 11 both edges. Edges of any other kind start nothing.
- R4: A qualifying edge produces exactly count+1 request pulses, for any count from 0 to 31. After each acknowledge, `dma_req` is low for at least one cycle.
- R5: `dma_req` rises in the cycle after the clock edge that first samples the trigger change. It stays high until `dma_ack` is sampled high.
- R6: A write to the control word while the generator is enabled leaves the count field unchanged. The other fields do take the written value.
- R7: A qualifying edge that arrives while a burst is in progress sets the overrun flag (status bit 0). That edge does not change the number of requests in the running burst.
- R8: Writing 1 to bit 0 at address 2 clears the overrun flag. Writing 0 there leaves the flag unchanged.
- R9: `irq` is high exactly when the overrun flag and the interrupt enable bit are both set.
- R10: Clearing the enable bit drops `dma_req` in the cycle after the write and abandons the burst. The next burst after re-enabling has the full count.
- R11: While the generator is disabled, trigger edges produce no requests and set no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; zeroes configuration and flag |
| trig_in | input | NUM_TRIG | Candidate trigger inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 clear) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from address |
| dma_req | output | 1 | Generated DMA request |
| dma_ack | input | 1 | Acknowledge of the current request |
| irq | output | 1 | Overrun interrupt |

## Verification
The assertions check the following on every cycle:
- the request handshake: the request is held until acknowledged and dropped after each acknowledge;
- that a burst can only start while the generator is enabled;
- that the overrun flag is sticky, is set by an overrun event and is cleared by a clear write.

Only the bench's scenarios can show the rest:
- that the burst length equals count+1 across the count range;
- that only the selected input and only the programmed edge kind start a burst, swept over every select and edge-kind combination;
- that the count field is frozen while the generator is enabled, and that an overrun leaves the running burst intact;
- that a disable abandons a burst and the next burst starts again at the full count.

// File: rtl/trg_gen_pkg.sv
package trg_gen_pkg;

    // register addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_CLEAR  = 2'd2;

    // control word field positions
    localparam int EN_BIT  = 0;
    localparam int IE_BIT  = 1;
    localparam int POL_LSB = 2;
    localparam int CNT_LSB = 4;
    localparam int SEL_LSB = 16;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } edge_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ASSERT  = 2'd1,
        ST_RELEASE = 2'd2
    } gen_state_e;

endpackage

// File: rtl/trg_edge_detect.sv
module trg_edge_detect
    import trg_gen_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    sig_sel,
    input  edge_kind_e          edge_kind,
    output logic                edge_hit
);

    logic sel_now;
    logic prev_q;
    logic rise;
    logic fall;

    always_comb begin
        sel_now = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (SEL_W'(i) == sig_sel) sel_now = trig_in[i];
        end
    end

    // previous value of the selected input, tracked even while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_now;
    end

    assign rise = sel_now & ~prev_q;
    assign fall = ~sel_now & prev_q;

    always_comb begin
        unique case (edge_kind)
            POL_NONE: edge_hit = 1'b0;
            POL_RISE: edge_hit = rise;
            POL_FALL: edge_hit = fall;
            POL_BOTH: edge_hit = rise | fall;
            default:  edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/trg_cfg_regs.sv
module trg_cfg_regs
    import trg_gen_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    parameter int CNT_W    = 5,
    parameter int DATA_W   = 32,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ovr_set,
    output logic              gen_en,
    output logic              irq_en,
    output edge_kind_e        edge_kind,
    output logic [CNT_W-1:0]  cnt_max,
    output logic [SEL_W-1:0]  sig_sel,
    output logic              ovr_flag,
    output logic              clr_hit
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_d;
    logic              ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign clr_hit = reg_wr && (reg_addr == ADDR_CLEAR) && reg_wdata[0];

    // count field frozen while the generator runs
    always_comb begin
        ctrl_d = reg_wdata;
        if (ctrl_q[EN_BIT]) ctrl_d[CNT_LSB +: CNT_W] = ctrl_q[CNT_LSB +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_d;
    end

    // sticky overrun flag; a new overrun wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (ovr_set) ovr_flag <= 1'b1;
        else if (clr_hit) ovr_flag <= 1'b0;
    end

    assign gen_en    = ctrl_q[EN_BIT];
    assign irq_en    = ctrl_q[IE_BIT];
    assign edge_kind = edge_kind_e'(ctrl_q[POL_LSB +: 2]);
    assign cnt_max   = ctrl_q[CNT_LSB +: CNT_W];
    assign sig_sel   = ctrl_q[SEL_LSB +: SEL_W];

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = ctrl_q;
            ADDR_STATUS: reg_rdata = DATA_W'(ovr_flag);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trg_burst_fsm.sv
module trg_burst_fsm
    import trg_gen_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             edge_hit,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             ovr_set
);

    gen_state_e       state_q;
    gen_state_e       state_d;
    logic [CNT_W-1:0] remain_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (edge_hit) state_d = ST_ASSERT;                 // launch
            ST_ASSERT:  if (dma_ack)
                            state_d = (remain_q == '0) ? ST_IDLE          // done
                                                       : ST_RELEASE;      // next
            ST_RELEASE: state_d = ST_ASSERT;                               // rearm
            default:    state_d = ST_IDLE;
        endcase
        if (!gen_en) state_d = ST_IDLE;                                    // abort
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // requests still owed after the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (!gen_en || (state_q == ST_IDLE))
            remain_q <= cnt_max;
        else if ((state_q == ST_ASSERT) && dma_ack && (remain_q != '0))
            remain_q <= remain_q - 1'b1;
    end

    // outputs
    always_comb begin
        dma_req = gen_en && (state_q == ST_ASSERT);
        ovr_set = gen_en && edge_hit && (state_q != ST_IDLE);
    end

endmodule

// File: rtl/trig_req_gen.sv
module trig_req_gen
    import trg_gen_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    parameter int CNT_W    = 5,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                dma_req,
    input  logic                dma_ack,
    output logic                irq
);

    localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic             gen_en;
    logic             irq_en;
    edge_kind_e       edge_kind;
    logic [CNT_W-1:0] cnt_max;
    logic [SEL_W-1:0] sig_sel;
    logic             ovr_flag;
    logic             ovr_set;
    logic             clr_hit;
    logic             edge_hit;

    trg_cfg_regs #(
        .NUM_TRIG (NUM_TRIG),
        .CNT_W    (CNT_W),
        .DATA_W   (DATA_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovr_set   (ovr_set),
        .gen_en    (gen_en),
        .irq_en    (irq_en),
        .edge_kind (edge_kind),
        .cnt_max   (cnt_max),
        .sig_sel   (sig_sel),
        .ovr_flag  (ovr_flag),
        .clr_hit   (clr_hit)
    );

    trg_edge_detect #(
        .NUM_TRIG (NUM_TRIG)
    ) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .sig_sel   (sig_sel),
        .edge_kind (edge_kind),
        .edge_hit  (edge_hit)
    );

    trg_burst_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en   (gen_en),
        .edge_hit (edge_hit),
        .cnt_max  (cnt_max),
        .dma_ack  (dma_ack),
        .dma_req  (dma_req),
        .ovr_set  (ovr_set)
    );

    assign irq = ovr_flag && irq_en;

endmodule

// File: rtl/trg_gen_checker.sv
module trg_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_req,
    input logic dma_ack,
    input logic gen_en,
    input logic ovr_flag,
    input logic ovr_set,
    input logic clr_hit,
    input logic irq
);

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> (dma_req || !gen_en));

    a_r4_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    a_r11_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(gen_en));

    a_r7_overrun_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> ovr_flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_hit) |=> ovr_flag);

    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !ovr_set) |=> !ovr_flag);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovr_flag);

endmodule

bind trig_req_gen trg_gen_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack),
    .gen_en   (gen_en),
    .ovr_flag (ovr_flag),
    .ovr_set  (ovr_set),
    .clr_hit  (clr_hit),
    .irq      (irq)
);

// File: tb/trig_req_gen_tb_top.sv
module trig_req_gen_tb_top;

    localparam int NT = 8;
    localparam int CW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig_in = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dma_req;
    logic          dma_ack = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_req_gen #(.NUM_TRIG(NT), .CNT_W(CW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl(int en, int ie, int pol, int cnt, int sel);
        return DW'((sel << 16) | (cnt << 4) | (pol << 2) | (ie << 1) | en);
    endfunction

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic set_trig(int idx, logic val);
        @(negedge clk);
        trig_in[idx] = val;
    endtask

    // acknowledge every request seen; count them
    task automatic count_reqs(int win, output int n);
        n = 0;
        repeat (win) begin
            @(negedge clk);
            if (dma_req) begin n++; dma_ack = 1'b1; end
            else dma_ack = 1'b0;
        end
        dma_ack = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, n, highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADDR_C(), v); chk("R1 ctrl", v, 0);
        rd(2'd1, v);     chk("R1 status", v, 0);
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 irq", int'(irq), 0);

        // R3 R4 sweep over select, edge kind and counts
        for (int sel = 0; sel < NT; sel++) begin
            for (int pol = 0; pol < 4; pol++) begin
                int cnt = (sel * 3 + pol) % 8;
                wr(2'd0, ctrl(0, 0, pol, cnt, sel));
                wr(2'd0, ctrl(1, 0, pol, cnt, sel));
                set_trig(sel, 1'b1);
                count_reqs(2 * cnt + 6, n);
                chk("R3 R4 rising", n, (pol & 1) ? cnt + 1 : 0);
                set_trig(sel, 1'b0);
                count_reqs(2 * cnt + 6, n);
                chk("R3 R4 falling", n, (pol & 2) ? cnt + 1 : 0);
                wr(2'd0, ctrl(0, 0, pol, cnt, sel));
            end
        end

        // R2 other inputs ignored
        wr(2'd0, ctrl(1, 0, 3, 0, 3));
        highs = 0;
        for (int i = 0; i < NT; i++) begin
            if (i != 3) begin
                set_trig(i, 1'b1); count_reqs(4, n); highs += n;
                set_trig(i, 1'b0); count_reqs(4, n); highs += n;
            end
        end
        chk("R2 unselected inputs", highs, 0);
        wr(2'd0, ctrl(0, 0, 3, 0, 3));

        // R4 maximum count
        wr(2'd0, ctrl(1, 0, 1, 31, 2));
        set_trig(2, 1'b1);
        count_reqs(80, n);
        chk("R4 count 31", n, 32);
        set_trig(2, 1'b0);
        wr(2'd0, ctrl(0, 0, 1, 31, 2));

        // R5 timing and hold
        wr(2'd0, ctrl(1, 0, 1, 2, 1));
        set_trig(1, 1'b1);
        @(negedge clk);
        chk("R5 first cycle", int'(dma_req), 1);
        highs = 0;
        repeat (10) begin @(negedge clk); if (dma_req) highs++; end
        chk("R5 hold without ack", highs, 10);
        count_reqs(12, n);
        chk("R5 burst after hold", n, 3);
        set_trig(1, 1'b0);

        // R6 count frozen while enabled
        wr(2'd0, ctrl(1, 0, 1, 9, 1));
        rd(2'd0, v);
        chk("R6 count field", (v >> 4) & 31, 2);
        set_trig(1, 1'b1);
        count_reqs(12, n);
        chk("R6 burst length", n, 3);
        set_trig(1, 1'b0);

        // R7 overrun
        wr(2'd0, ctrl(0, 0, 1, 3, 4));
        wr(2'd0, ctrl(1, 0, 1, 3, 4));
        set_trig(4, 1'b1);
        set_trig(4, 1'b0);
        set_trig(4, 1'b1);
        rd(2'd1, v);
        chk("R7 flag set", v, 1);
        chk("R9 irq masked", int'(irq), 0);
        count_reqs(14, n);
        chk("R7 burst intact", n, 4);
        set_trig(4, 1'b0);

        // R9 interrupt
        wr(2'd0, ctrl(1, 1, 1, 3, 4));
        @(negedge clk);
        chk("R9 irq on", int'(irq), 1);

        // R8 clear
        wr(2'd2, 32'd0);
        rd(2'd1, v);
        chk("R8 clear zero ignored", v, 1);
        wr(2'd2, 32'd1);
        rd(2'd1, v);
        chk("R8 clear one", v, 0);
        chk("R9 irq off", int'(irq), 0);

        // R10 abort
        set_trig(4, 1'b1);
        @(negedge clk);
        chk("R10 req before disable", int'(dma_req), 1);
        wr(2'd0, ctrl(0, 1, 1, 3, 4));
        chk("R10 req dropped", int'(dma_req), 0);
        set_trig(4, 1'b0);
        wr(2'd0, ctrl(1, 1, 1, 3, 4));
        set_trig(4, 1'b1);
        count_reqs(14, n);
        chk("R10 full burst after re-enable", n, 4);
        set_trig(4, 1'b0);

        // R11 disabled
        wr(2'd0, ctrl(0, 1, 3, 3, 4));
        set_trig(4, 1'b1); count_reqs(6, n); highs = n;
        set_trig(4, 1'b0); count_reqs(6, n); highs += n;
        chk("R11 no requests", highs, 0);
        rd(2'd1, v);
        chk("R11 no overrun", v, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [1:0] ADDR_C();
        return 2'd0;
    endfunction

endmodule